// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a short burst. A controller loads a full start address with a one-cycle strobe. Only the low `BURST_W` address bits step through the burst (two bits by default, so four beats). The upper bits stay as they were loaded. Each clock edge that samples the active-low advance input low moves the address to the next beat. When the advance input is high, the address holds.

A static order select chooses the beat order. When it is low, the order is linear: the start value plus the beat count, modulo the burst length. When it is high, the order is interleaved: the start value XORed with the beat count. Both orders come from one internal beat counter that is kept apart from the stored start value. After the last beat the counter wraps, and the sequence starts over at the start value.

The address output is a combinational function of two registered values, the stored start address and the beat count. It therefore changes one edge after a load or an advance. Strobe decoding and the memory array are outside this block. It only receives the load and advance qualifiers.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and on the first edge after it, `addr_o` is all zeros.
- R2: The edge that samples `load_i` high stores `start_addr_i`, and `addr_o` equals it from that edge on.
- R3: The bits of `addr_o` above the burst field keep their loaded value until the next load, through any number of advances.
- R4: With `order_sel_i` low (linear), the burst field of `addr_o` on beat k (k = 0..3) is (start + k) mod 4. For a start of 01 this gives 01, 10, 11, 00.
- R5: With `order_sel_i` high (interleaved), the burst field on beat k is start XOR k. For a start of 01 this gives 01, 00, 11, 10.
- R6: After four advances the address returns to the loaded start value and the sequence repeats.
- R7: An edge with `load_i` low and `adv_n_i` high leaves `addr_o` unchanged.
- R8: On an edge with `load_i` high, `adv_n_i` is ignored. `addr_o` equals the new start address exactly, and the beat count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for a new start address |
| start_addr_i | input | ADDR_W | Start address captured on load |
| adv_n_i | input | 1 | Advance to the next beat when sampled low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved (static during a burst) |
| addr_o | output | ADDR_W | Current beat address |

## Verification
A corrupted beat count shows as a wrong burst field on `addr_o` one edge after the advance that produced it. In interleaved order a wrong count gives a different code than in linear order, so the two orders are checked against separate expected sequences for every start value. A lost start value shows up at the latest at the wrap, four advances after the load, when the address fails to return to its start. A fault in the upper bits is visible on the first edge after the load.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

   // Which burst orders an instance builds.
   typedef enum logic [1:0] {
      ORD_BOTH       = 2'd0,
      ORD_LINEAR     = 2'd1,
      ORD_INTERLEAVE = 2'd2
   } order_set_e;

   // Linear beat: start plus beat count, wrapping in the field width.
   function automatic logic [3:0] lin_beat(input logic [3:0] start, input logic [3:0] beat);
      return start + beat;
   endfunction

   // Interleaved beat: start XORed with the beat count.
   function automatic logic [3:0] ilv_beat(input logic [3:0] start, input logic [3:0] beat);
      return start ^ beat;
   endfunction

endpackage

// File: rtl/bag_start_reg.sv
module bag_start_reg #(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic [ADDR_W-1:0] start_q_o
);

   logic [ADDR_W-1:0] start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (load_i) begin
         start_q <= start_addr_i;
      end
   end

   assign start_q_o = start_q;

endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               adv_n_i,
   output logic [BURST_W-1:0] beat_o
);

   logic [BURST_W-1:0] beat_q;
   logic [BURST_W-1:0] beat_d;

   // A load wins over an advance and restarts the count.
   always_comb begin
      beat_d = beat_q;
      if (load_i) begin
         beat_d = '0;
      end else if (!adv_n_i) begin
         beat_d = beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else begin
         beat_q <= beat_d;
      end
   end

   assign beat_o = beat_q;

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
   import burst_ctr_pkg::*;
#(
   parameter int         BURST_W   = 2,
   parameter order_set_e ORDER_SET = ORD_BOTH
) (
   input  logic [BURST_W-1:0] start_low_i,
   input  logic [BURST_W-1:0] beat_i,
   input  logic               order_sel_i,
   output logic [BURST_W-1:0] low_o
);

   logic [3:0] start_ext;
   logic [3:0] beat_ext;
   logic [3:0] lin_full;
   logic [3:0] ilv_full;
   logic [BURST_W-1:0] lin_low;
   logic [BURST_W-1:0] ilv_low;

   assign start_ext = 4'(start_low_i);
   assign beat_ext  = 4'(beat_i);
   assign lin_full  = lin_beat(start_ext, beat_ext);
   assign ilv_full  = ilv_beat(start_ext, beat_ext);
   assign lin_low   = lin_full[BURST_W-1:0];
   assign ilv_low   = ilv_full[BURST_W-1:0];

   generate
      if (ORDER_SET == ORD_LINEAR) begin : g_lin_only
         logic unused_sel;
         logic [BURST_W-1:0] unused_ilv;
         assign unused_sel = order_sel_i;
         assign unused_ilv = ilv_low;
         assign low_o = lin_low;
      end else if (ORDER_SET == ORD_INTERLEAVE) begin : g_ilv_only
         logic unused_sel;
         logic [BURST_W-1:0] unused_lin;
         assign unused_sel = order_sel_i;
         assign unused_lin = lin_low;
         assign low_o = ilv_low;
      end else begin : g_both
         assign low_o = order_sel_i ? ilv_low : lin_low;
      end
   endgenerate

   if (BURST_W < 4) begin : g_unused_hi
      logic [3-BURST_W:0] unused_hi;
      assign unused_hi = lin_full[3:BURST_W] ^ ilv_full[3:BURST_W];
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_ctr_pkg::*;
#(
   parameter int         ADDR_W    = 18,
   parameter int         BURST_W   = 2,
   parameter order_set_e ORDER_SET = ORD_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              adv_n_i,
   input  logic              order_sel_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int BEATS = 1 << BURST_W;

   if (BURST_W < 1 || BURST_W > 4) begin : g_bad_burst
      $error("burst_addr_gen: BURST_W must be 1..4");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed BURST_W");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("burst_addr_gen: burst needs at least two beats");
   end

   logic [ADDR_W-1:0]  start_q;
   logic [BURST_W-1:0] beat;
   logic [BURST_W-1:0] low;

   bag_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .start_addr_i (start_addr_i),
      .start_q_o    (start_q)
   );

   bag_beat_cnt #(.BURST_W(BURST_W)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_n_i (adv_n_i),
      .beat_o  (beat)
   );

   bag_order_map #(.BURST_W(BURST_W), .ORDER_SET(ORDER_SET)) u_map (
      .start_low_i (start_q[BURST_W-1:0]),
      .beat_i      (beat),
      .order_sel_i (order_sel_i),
      .low_o       (low)
   );

   assign addr_o = {start_q[ADDR_W-1:BURST_W], low};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W  = 18,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic              adv_n_i,
   input logic              order_sel_i,
   input logic [ADDR_W-1:0] addr_o
);

   AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(start_addr_i))); // R8

   AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:BURST_W])); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> ($stable(addr_o) || (order_sel_i != $past(order_sel_i)))); // R7

   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && !order_sel_i) |=>
         (order_sel_i || (addr_o[BURST_W-1:0] == BURST_W'($past(addr_o[BURST_W-1:0]) + 1'b1)))); // R4

   AST_ILV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && order_sel_i) |=>
         (!order_sel_i || (addr_o[BURST_W-1:0] != $past(addr_o[BURST_W-1:0])))); // R5

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic          adv_n_i = 1'b1;
   logic          order_sel_i = 1'b0;
   logic [AW-1:0] addr_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .start_addr_i (start_addr_i),
      .adv_n_i      (adv_n_i),
      .order_sel_i  (order_sel_i),
      .addr_o       (addr_o)
   );

   task automatic check(input string req, input logic [AW-1:0] exp);
      n_chk++;
      if (addr_o !== exp) begin
         n_err++;
         $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
      end
   endtask

   task automatic edge_drive(input logic ld, input logic [AW-1:0] st, input logic advn);
      @(negedge clk);
      load_i = ld;
      start_addr_i = st;
      adv_n_i = advn;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] st, input bit ilv, input int k);
      logic [1:0] lo;
      lo = ilv ? (st[1:0] ^ 2'(k)) : 2'(int'(st[1:0]) + k);
      return {st[AW-1:2], lo};
   endfunction

   initial begin
      #1;
      check("R1", '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", '0);

      for (int m = 0; m < 2; m++) begin
         for (int up = 0; up < 2; up++) begin
            for (int s = 0; s < 4; s++) begin
               logic [AW-1:0] st;
               st = {(up == 0) ? 16'h2A5C : 16'hD3F1, 2'(s)};
               @(negedge clk);
               order_sel_i = m[0];
               edge_drive(1'b1, st, 1'b1);
               check("R2", st);
               for (int k = 1; k <= 4; k++) begin
                  edge_drive(1'b0, ~st, 1'b0);
                  check(m ? "R5" : "R4", expect_addr(st, m[0], k));
                  if (addr_o[AW-1:2] !== st[AW-1:2]) begin
                     n_err++;
                     $display("FAIL R3: upper=%h expected=%h", addr_o[AW-1:2], st[AW-1:2]);
                  end
                  n_chk++;
                  edge_drive(1'b0, ~st, 1'b1);
                  check("R7", expect_addr(st, m[0], k));
               end
               check("R6", st);
            end
         end
      end

      order_sel_i = 1'b0;
      edge_drive(1'b1, 18'h00011, 1'b1);
      edge_drive(1'b0, '0, 1'b0);
      edge_drive(1'b1, 18'h3C002, 1'b0);
      check("R8", 18'h3C002);
      edge_drive(1'b0, '0, 1'b0);
      check("R8", 18'h3C003);
      @(negedge clk);
      order_sel_i = 1'b1;
      edge_drive(1'b1, 18'h15553, 1'b0);
      check("R8", 18'h15553);
      edge_drive(1'b0, '0, 1'b0);
      check("R5", 18'h15552);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule